// File: doc/BRIEF.md
# Masked CAM Array with Movable RAM Partition

This block is a 64-entry content-addressable memory. Each entry holds 64 data bits and a 2-bit validity code. A run-time partition code splits every entry into a searched CAM field and an unsearched RAM field. The RAM field holds data tied to the key stored at the same entry. A compare request checks the comparand against the CAM field of every live entry. A selectable mask can exclude more bits from the compare. One cycle later the block reports a match flag and the lowest-numbered matching entry.

The block always shows the lowest empty entry and a full flag. Writes and reads pick their entry from one of four sources: a direct address, an internal address register, the next free entry, or the last match address. A mask can protect selected bits of a write. The first mask register has two banks, foreground and background. The foreground bank is active after reset.

The compare result is held by a small state machine with three named states. RES_IDLE means no compare has run since reset. RES_HIT means the last compare found a live entry. RES_MISS means it found none. There are two transitions, and each is taken from any state. A compare request that hits goes to RES_HIT. A compare request that misses goes to RES_MISS. With no request the state stays where it is.

Top module: `cam_partition_array`

## Requirements
- R1: After reset every entry is empty with zero data, all mask registers are zero, match_flag, match_addr, next_free, rd_data and rd_vbits are 0, and full is 0.
- R2: Validity code 2'b11 marks an entry empty. 2'b00 marks it live and searchable. 2'b01 and 2'b10 mark it occupied: it is skipped by compares and is not free.
- R3: Partition code ctl_split = k, for k from 1 to 4, makes k*16 bits RAM. With ctl_ram_high = 0 these are the low bits; with ctl_ram_high = 1 they are the high bits. Codes 0 and 5 to 7 leave the whole entry CAM. RAM bits never affect a compare.
- R4: ctl_cmp_mask selects the compare mask: 2'b01 is the active mask-1 bank, 2'b10 is mask 2, and 2'b00 or 2'b11 is no mask. A mask bit of 1 excludes that bit from the compare; a mask bit of 0 includes it.
- R5: When mask_we is 1, mask_id 0 loads the mask-1 foreground bank, 1 loads the mask-1 background bank, 2 loads mask 2, and 3 loads nothing. ctl_m1_bank = 0 makes the foreground bank active and 1 makes the background bank active.
- R6: The cycle after cmp_req, match_flag shows whether any live entry matched. match_addr then shows the lowest-numbered matching entry, or 0 on a miss. Both hold their values until the next compare. A compare sees the array as it was before any write in the same cycle.
- R7: A write stores (old & m) | (wr_data & ~m), where m is the mask picked by wr_mask with the same encoding as ctl_cmp_mask. wr_vbits is always stored unmasked.
- R8: wr_src and rd_src pick the entry: 0 is rd_addr or wr_addr, 1 is the address register (loaded by areg_we), 2 is next_free, and 3 is the last match_addr. A register loaded in the same cycle takes effect one cycle later.
- R9: next_free is the lowest-numbered empty entry. full is 1 when no entry is empty, and next_free is then 0.
- R10: A write or read from source 2 while full is 1 does nothing. A write or read from source 3 while match_flag is 0 also does nothing.
- R11: A read loads rd_data and rd_vbits from the chosen entry one cycle after rd_req. The read sees the array as it was before any write in the same cycle. An ignored read, or no read, leaves both outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_split | input | 3 | CAM/RAM partition code |
| ctl_ram_high | input | 1 | 1 puts the RAM field at the high end |
| ctl_cmp_mask | input | 2 | Compare mask select |
| ctl_m1_bank | input | 1 | Active mask-1 bank (0 foreground, 1 background) |
| mask_we | input | 1 | Mask register load strobe |
| mask_id | input | 2 | Mask register to load |
| mask_wdata | input | 64 | Mask load value |
| areg_we | input | 1 | Address register load strobe |
| areg_wdata | input | 6 | Address register load value |
| cmp_req | input | 1 | Compare request |
| comparand | input | 64 | Search key |
| wr_req | input | 1 | Write request |
| wr_src | input | 2 | Write address source |
| wr_addr | input | 6 | Direct write address |
| wr_data | input | 64 | Write data |
| wr_vbits | input | 2 | Validity code to store |
| wr_mask | input | 2 | Write mask select |
| rd_req | input | 1 | Read request |
| rd_src | input | 2 | Read address source |
| rd_addr | input | 6 | Direct read address |
| match_flag | output | 1 | Last compare hit |
| match_addr | output | 6 | Lowest matching entry of the last compare |
| next_free | output | 6 | Lowest empty entry |
| full | output | 1 | No empty entry |
| rd_data | output | 64 | Read data |
| rd_vbits | output | 2 | Read validity code |

## Verification
Keys are drawn from a pool of four values, so several entries often match at once. This checks that the lowest entry wins rather than any matching one. Comparands differ from stored keys only in a flipped nibble that sits in the RAM field or under a mask. A hit then shows the exclusion worked, and the same comparand under partition code 0 or with no mask must miss. Writes that store the occupied codes, writes through a sparse protecting mask, and a fill that runs past the last empty entry separate liveness from emptiness. They also separate preserved bits from updated bits, and an ignored write from a write to entry 0.

// File: rtl/cam_pkg.sv
package cam_pkg;
    typedef enum logic [1:0] {
        SRC_DIRECT = 2'd0,
        SRC_AREG   = 2'd1,
        SRC_FREE   = 2'd2,
        SRC_MATCH  = 2'd3
    } addr_src_e;

    typedef enum logic [1:0] {
        MSEL_NONE  = 2'd0,
        MSEL_M1    = 2'd1,
        MSEL_M2    = 2'd2,
        MSEL_NONE3 = 2'd3
    } mask_sel_e;

    typedef enum logic [1:0] {
        RES_IDLE = 2'd0,
        RES_HIT  = 2'd1,
        RES_MISS = 2'd2
    } res_state_e;

    localparam logic [1:0] VB_EMPTY = 2'b11;
    localparam logic [1:0] VB_LIVE  = 2'b00;
endpackage

// File: rtl/cam_field_map.sv
module cam_field_map #(
    parameter int WIDTH  = 64,
    parameter int SEG    = 16,
    parameter int CODE_W = 3
) (
    input  logic [CODE_W-1:0] split,
    input  logic              ram_high,
    output logic [WIDTH-1:0]  ram_bits
);
    localparam int NSEG = WIDTH / SEG;

    int nram;

    always_comb begin
        if (int'(split) >= 1 && int'(split) <= NSEG) begin
            nram = int'(split) * SEG;
        end else begin
            nram = 0;
        end
        for (int b = 0; b < WIDTH; b++) begin
            if (ram_high) begin
                ram_bits[b] = (b >= WIDTH - nram);
            end else begin
                ram_bits[b] = (b < nram);
            end
        end
    end
endmodule

// File: rtl/cam_mask_bank.sv
module cam_mask_bank
    import cam_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we,
    input  logic [1:0]       mask_id,
    input  logic [WIDTH-1:0] mask_wdata,
    input  logic             m1_bank,
    input  logic [1:0]       cmp_sel,
    input  logic [1:0]       wr_sel,
    output logic [WIDTH-1:0] cmp_mask,
    output logic [WIDTH-1:0] wr_mask_val
);
    logic [WIDTH-1:0] m1_fg_q, m1_bg_q, m2_q;
    logic [WIDTH-1:0] m1_act;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m1_fg_q <= '0;
            m1_bg_q <= '0;
            m2_q    <= '0;
        end else if (mask_we) begin
            unique case (mask_id)
                2'd0:    m1_fg_q <= mask_wdata;
                2'd1:    m1_bg_q <= mask_wdata;
                2'd2:    m2_q    <= mask_wdata;
                default: ;
            endcase
        end
    end

    assign m1_act = m1_bank ? m1_bg_q : m1_fg_q;

    function automatic logic [WIDTH-1:0] pick(input logic [1:0] sel,
                                              input logic [WIDTH-1:0] a,
                                              input logic [WIDTH-1:0] b);
        unique case (mask_sel_e'(sel))
            MSEL_M1: pick = a;
            MSEL_M2: pick = b;
            default: pick = '0;
        endcase
    endfunction

    assign cmp_mask    = pick(cmp_sel, m1_act, m2_q);
    assign wr_mask_val = pick(wr_sel, m1_act, m2_q);
endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
    parameter int N  = 64,
    parameter int AW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [AW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = AW'(i);
            end
        end
    end
endmodule

// File: rtl/cam_partition_array.sv
module cam_partition_array
    import cam_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int WIDTH   = 64,
    parameter int SEG     = 16,
    parameter int CODE_W  = 3,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ctl_split,
    input  logic              ctl_ram_high,
    input  logic [1:0]        ctl_cmp_mask,
    input  logic              ctl_m1_bank,
    input  logic              mask_we,
    input  logic [1:0]        mask_id,
    input  logic [WIDTH-1:0]  mask_wdata,
    input  logic              areg_we,
    input  logic [AW-1:0]     areg_wdata,
    input  logic              cmp_req,
    input  logic [WIDTH-1:0]  comparand,
    input  logic              wr_req,
    input  logic [1:0]        wr_src,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [1:0]        wr_vbits,
    input  logic [1:0]        wr_mask,
    input  logic              rd_req,
    input  logic [1:0]        rd_src,
    input  logic [AW-1:0]     rd_addr,
    output logic              match_flag,
    output logic [AW-1:0]     match_addr,
    output logic [AW-1:0]     next_free,
    output logic              full,
    output logic [WIDTH-1:0]  rd_data,
    output logic [1:0]        rd_vbits
);
    logic [WIDTH-1:0]        mem_q [ENTRIES];
    logic [ENTRIES-1:0][1:0] vld_q;
    logic [AW-1:0]           areg_q;
    logic [AW-1:0]           match_addr_q;
    logic [WIDTH-1:0]        rd_data_q;
    logic [1:0]              rd_vbits_q;
    res_state_e              res_q, res_d;

    logic [WIDTH-1:0]   ram_bits, cmp_mask, wmask, care;
    logic [ENTRIES-1:0] hit_vec, free_vec;
    logic               hit_any, free_any;
    logic [AW-1:0]      hit_idx, free_idx;
    logic [AW-1:0]      wr_idx, rd_idx;
    logic               wr_ok, rd_ok, wr_go, rd_go;
    logic [WIDTH-1:0]   wr_old;

    cam_field_map #(.WIDTH(WIDTH), .SEG(SEG), .CODE_W(CODE_W)) u_map (
        .split    (ctl_split),
        .ram_high (ctl_ram_high),
        .ram_bits (ram_bits)
    );

    cam_mask_bank #(.WIDTH(WIDTH)) u_masks (
        .clk         (clk),
        .rst_n       (rst_n),
        .mask_we     (mask_we),
        .mask_id     (mask_id),
        .mask_wdata  (mask_wdata),
        .m1_bank     (ctl_m1_bank),
        .cmp_sel     (ctl_cmp_mask),
        .wr_sel      (wr_mask),
        .cmp_mask    (cmp_mask),
        .wr_mask_val (wmask)
    );

    assign care = ~ram_bits & ~cmp_mask;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        assign hit_vec[i]  = (vld_q[i] == VB_LIVE) &&
                             (((mem_q[i] ^ comparand) & care) == '0);
        assign free_vec[i] = (vld_q[i] == VB_EMPTY);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
                vld_q[i] <= VB_EMPTY;
            end else if (wr_go && wr_idx == AW'(i)) begin
                mem_q[i] <= (mem_q[i] & wmask) | (wr_data & ~wmask);
                vld_q[i] <= wr_vbits;
            end
        end
    end

    cam_prio_enc #(.N(ENTRIES), .AW(AW)) u_hit_enc (
        .req (hit_vec),
        .any (hit_any),
        .idx (hit_idx)
    );

    cam_prio_enc #(.N(ENTRIES), .AW(AW)) u_free_enc (
        .req (free_vec),
        .any (free_any),
        .idx (free_idx)
    );

    // address source resolution, shared encoding for both ports
    always_comb begin
        unique case (addr_src_e'(wr_src))
            SRC_DIRECT: begin wr_idx = wr_addr;      wr_ok = 1'b1;             end
            SRC_AREG:   begin wr_idx = areg_q;       wr_ok = 1'b1;             end
            SRC_FREE:   begin wr_idx = free_idx;     wr_ok = free_any;         end
            SRC_MATCH:  begin wr_idx = match_addr_q; wr_ok = (res_q == RES_HIT); end
            default:    begin wr_idx = '0;           wr_ok = 1'b0;             end
        endcase
        unique case (addr_src_e'(rd_src))
            SRC_DIRECT: begin rd_idx = rd_addr;      rd_ok = 1'b1;             end
            SRC_AREG:   begin rd_idx = areg_q;       rd_ok = 1'b1;             end
            SRC_FREE:   begin rd_idx = free_idx;     rd_ok = free_any;         end
            SRC_MATCH:  begin rd_idx = match_addr_q; rd_ok = (res_q == RES_HIT); end
            default:    begin rd_idx = '0;           rd_ok = 1'b0;             end
        endcase
    end

    assign wr_go  = wr_req && wr_ok;
    assign rd_go  = rd_req && rd_ok;
    assign wr_old = mem_q[wr_idx];

    // result state machine: next state
    always_comb begin
        res_d = res_q;
        unique case (res_q)
            RES_IDLE, RES_HIT, RES_MISS: begin
                if (cmp_req) begin
                    res_d = hit_any ? RES_HIT : RES_MISS;
                end
            end
            default: res_d = RES_IDLE;
        endcase
    end

    // state register and registered side data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q        <= RES_IDLE;
            match_addr_q <= '0;
            areg_q       <= '0;
            rd_data_q    <= '0;
            rd_vbits_q   <= '0;
        end else begin
            res_q <= res_d;
            if (cmp_req) begin
                match_addr_q <= hit_any ? hit_idx : '0;
            end
            if (areg_we) begin
                areg_q <= areg_wdata;
            end
            if (rd_go) begin
                rd_data_q  <= mem_q[rd_idx];
                rd_vbits_q <= vld_q[rd_idx];
            end
        end
    end

    // outputs
    always_comb begin
        match_flag = (res_q == RES_HIT);
        match_addr = match_addr_q;
        full       = ~free_any;
        next_free  = free_any ? free_idx : '0;
        rd_data    = rd_data_q;
        rd_vbits   = rd_vbits_q;
    end

    a_r6_flag_follows_compare: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_req |=> (match_flag == $past(hit_any)));

    a_r6_lowest_entry_reported: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_req && hit_any) |=> (match_addr == $past(hit_idx)));

    a_r6_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_req |=> ($stable(match_flag) && $stable(match_addr)));

    a_r7_protected_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> (((mem_q[$past(wr_idx)] ^ $past(wr_old)) & $past(wmask)) == '0));

    a_r9_free_entry_is_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !full |-> (vld_q[next_free] == VB_EMPTY));

    a_r9_full_entry0_taken: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (vld_q[0] != VB_EMPTY && next_free == '0));

    a_r10_full_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_src == 2'd2 && full) |=> $stable(vld_q));

    a_r11_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> ($stable(rd_data) && $stable(rd_vbits)));
endmodule

// File: tb/cam_partition_array_test.sv
module cam_partition_array_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ctl_split = '0;
    logic        ctl_ram_high = 1'b0;
    logic [1:0]  ctl_cmp_mask = '0;
    logic        ctl_m1_bank = 1'b0;
    logic        mask_we = 1'b0;
    logic [1:0]  mask_id = '0;
    logic [63:0] mask_wdata = '0;
    logic        areg_we = 1'b0;
    logic [5:0]  areg_wdata = '0;
    logic        cmp_req = 1'b0;
    logic [63:0] comparand = '0;
    logic        wr_req = 1'b0;
    logic [1:0]  wr_src = '0;
    logic [5:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [1:0]  wr_vbits = '0;
    logic [1:0]  wr_mask = '0;
    logic        rd_req = 1'b0;
    logic [1:0]  rd_src = '0;
    logic [5:0]  rd_addr = '0;
    logic        match_flag, full;
    logic [5:0]  match_addr, next_free;
    logic [63:0] rd_data;
    logic [1:0]  rd_vbits;

    always #10 clk = ~clk;

    cam_partition_array uut (.*);

    int total = 0;
    int bad = 0;

    bit [63:0] m_mem [64];
    bit [1:0]  m_v [64];
    bit [63:0] m_m1f, m_m1b, m_m2;
    bit [5:0]  m_areg, m_maddr;
    bit        m_hit;
    bit [63:0] m_rd;
    bit [1:0]  m_rdv;
    bit [63:0] pool [4];

    function automatic bit [63:0] ram_fn(bit [2:0] c, bit hi);
        int n;
        bit [63:0] r;
        n = (c >= 1 && c <= 4) ? int'(c) * 16 : 0;
        r = '0;
        for (int b = 0; b < 64; b++) r[b] = hi ? (b >= 64 - n) : (b < n);
        return r;
    endfunction

    function automatic bit [63:0] mask_fn(bit [1:0] sel);
        if (sel == 2'd1) return ctl_m1_bank ? m_m1b : m_m1f;
        if (sel == 2'd2) return m_m2;
        return '0;
    endfunction

    function automatic int free_fn();
        for (int i = 0; i < 64; i++) if (m_v[i] == 2'b11) return i;
        return -1;
    endfunction

    function automatic int src_fn(bit [1:0] s, bit [5:0] d);
        int f;
        f = free_fn();
        case (s)
            2'd0: return int'(d);
            2'd1: return int'(m_areg);
            2'd2: return f;
            default: return m_hit ? int'(m_maddr) : -1;
        endcase
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        int f;
        f = free_fn();
        chk({tag, " R6 match_flag"}, 64'(match_flag), 64'(m_hit));
        chk({tag, " R6 match_addr"}, 64'(match_addr), 64'(m_maddr));
        chk({tag, " R9 full"}, 64'(full), 64'(f < 0));
        chk({tag, " R9 next_free"}, 64'(next_free), 64'(f < 0 ? 0 : f));
        chk({tag, " R11 rd_data"}, rd_data, m_rd);
        chk({tag, " R11 rd_vbits"}, 64'(rd_vbits), 64'(m_rdv));
    endtask

    // called at a falling edge with the inputs already driven
    task automatic do_op(string tag);
        bit [63:0] care, wm;
        int hi, wi, ri;
        care = ~ram_fn(ctl_split, ctl_ram_high) & ~mask_fn(ctl_cmp_mask);
        wm = mask_fn(wr_mask);
        hi = -1;
        for (int i = 63; i >= 0; i--)
            if (m_v[i] == 2'b00 && ((m_mem[i] ^ comparand) & care) == 0) hi = i;
        wi = src_fn(wr_src, wr_addr);
        ri = src_fn(rd_src, rd_addr);
        if (rd_req && ri >= 0) begin m_rd = m_mem[ri]; m_rdv = m_v[ri]; end
        if (cmp_req) begin m_hit = (hi >= 0); m_maddr = (hi >= 0) ? 6'(hi) : 6'd0; end
        if (wr_req && wi >= 0) begin
            m_mem[wi] = (m_mem[wi] & wm) | (wr_data & ~wm);
            m_v[wi] = wr_vbits;
        end
        if (areg_we) m_areg = areg_wdata;
        if (mask_we) begin
            if (mask_id == 2'd0) m_m1f = mask_wdata;
            else if (mask_id == 2'd1) m_m1b = mask_wdata;
            else if (mask_id == 2'd2) m_m2 = mask_wdata;
        end
        @(negedge clk);
        cmp_req = 0; wr_req = 0; rd_req = 0; areg_we = 0; mask_we = 0;
        check_all(tag);
    endtask

    task automatic wr(bit [1:0] s, bit [5:0] a, bit [63:0] d, bit [1:0] v, bit [1:0] m, string tag);
        wr_req = 1; wr_src = s; wr_addr = a; wr_data = d; wr_vbits = v; wr_mask = m;
        do_op(tag);
    endtask

    task automatic cmp(bit [63:0] key, string tag);
        cmp_req = 1; comparand = key;
        do_op(tag);
    endtask

    task automatic rd(bit [1:0] s, bit [5:0] a, string tag);
        rd_req = 1; rd_src = s; rd_addr = a;
        do_op(tag);
    endtask

    task automatic ldmask(bit [1:0] id, bit [63:0] v, string tag);
        mask_we = 1; mask_id = id; mask_wdata = v;
        do_op(tag);
    endtask

    localparam bit [63:0] KEY = 64'hA5A5_1234_5678_9ABC;

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) begin m_mem[i] = '0; m_v[i] = 2'b11; end
        m_m1f = '0; m_m1b = '0; m_m2 = '0; m_areg = '0; m_maddr = '0;
        m_hit = 0; m_rd = '0; m_rdv = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check_all("R1 reset");

        // R6: two equal keys, lowest wins; R2 occupied codes skipped
        wr(2'd0, 6'd9, KEY, 2'b00, 2'd0, "R8 direct");
        wr(2'd0, 6'd5, KEY, 2'b00, 2'd0, "R8 direct");
        cmp(KEY, "R6 lowest");
        wr(2'd0, 6'd5, KEY, 2'b01, 2'd0, "R2 occupied");
        cmp(KEY, "R2 skip 01");
        wr(2'd0, 6'd9, KEY, 2'b10, 2'd0, "R2 occupied");
        cmp(KEY, "R2 skip 10 miss");
        wr(2'd3, 6'd0, 64'h1, 2'b00, 2'd0, "R10 match src after miss");
        rd(2'd3, 6'd0, "R10 read match src after miss");
        wr(2'd0, 6'd9, KEY, 2'b00, 2'd0, "R2 relive");
        // R3 partition
        cmp(KEY ^ 64'h1, "R3 code0 miss");
        ctl_split = 3'd1; cmp(KEY ^ 64'h1, "R3 low16 ram hit");
        ctl_ram_high = 1; cmp(KEY ^ 64'h1, "R3 high16 miss");
        cmp(KEY ^ 64'h8000_0000_0000_0000, "R3 high16 hit");
        ctl_split = 3'd4; cmp(64'h0, "R3 all ram hit");
        ctl_split = 3'd6; cmp(64'h0, "R3 code6 miss");
        ctl_split = 3'd0; ctl_ram_high = 0;
        // R4 and R5 masks
        ldmask(2'd2, 64'h10, "R5 load m2");
        ctl_cmp_mask = 2'd2; cmp(KEY ^ 64'h10, "R4 m2 hit");
        ctl_cmp_mask = 2'd3; cmp(KEY ^ 64'h10, "R4 none miss");
        ldmask(2'd0, 64'h20, "R5 load fg");
        ldmask(2'd3, 64'hFFFF, "R5 id3 nothing");
        ctl_cmp_mask = 2'd1; cmp(KEY ^ 64'h20, "R5 fg hit");
        ctl_m1_bank = 1; cmp(KEY ^ 64'h20, "R5 bg miss");
        ldmask(2'd1, 64'hF00, "R5 load bg");
        cmp(KEY ^ 64'h300, "R5 bg hit");
        ctl_m1_bank = 0; ctl_cmp_mask = 2'd0;
        // R7 masked write through mask 2 (bit 4 protected)
        wr(2'd3, 6'd0, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 2'd2, "R7 masked write");
        rd(2'd0, 6'd9, "R7 readback");
        // R8 address register
        areg_we = 1; areg_wdata = 6'd33; do_op("R8 areg load");
        wr(2'd1, 6'd0, 64'hDEAD, 2'b00, 2'd0, "R8 areg write");
        rd(2'd1, 6'd0, "R8 areg read");

        // constrained random
        for (int i = 0; i < 64; i++) pool[i % 4] = {$urandom, $urandom};
        for (int n = 0; n < 1500; n++) begin
            if (n % 60 == 0) begin
                ctl_split = 3'($urandom % 8); ctl_ram_high = 1'($urandom);
                ctl_cmp_mask = 2'($urandom); ctl_m1_bank = 1'($urandom);
            end
            cmp_req = ($urandom % 2) == 0;
            comparand = pool[$urandom % 4] ^ (($urandom % 2) ? 64'($urandom % 16) << (4 * ($urandom % 16)) : 64'h0);
            wr_req = ($urandom % 5) < 2;
            wr_src = 2'($urandom); wr_addr = 6'($urandom % 24);
            wr_data = pool[$urandom % 4] ^ (($urandom % 4) == 0 ? 64'($urandom % 16) : 64'h0);
            wr_vbits = ($urandom % 10) < 6 ? 2'b00 : 2'($urandom);
            wr_mask = 2'($urandom);
            rd_req = ($urandom % 3) == 0; rd_src = 2'($urandom); rd_addr = 6'($urandom);
            areg_we = ($urandom % 10) == 0; areg_wdata = 6'($urandom % 24);
            mask_we = ($urandom % 10) == 0; mask_id = 2'($urandom);
            mask_wdata = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            do_op("R4 R6 R7 R8 random");
        end

        // R9 R10 fill past capacity through next-free
        ctl_split = 0; ctl_cmp_mask = 0;
        for (int i = 0; i < 70; i++) wr(2'd2, 6'd0, 64'(i) + 64'h100, 2'b00, 2'd0, "R9 R10 fill");
        rd(2'd2, 6'd0, "R10 read free when full");
        rd(2'd0, 6'd0, "R10 entry0 intact");
        wr(2'd0, 6'd40, 64'h0, 2'b11, 2'd0, "R9 reopen 40");
        wr(2'd2, 6'd0, 64'h77, 2'b00, 2'd0, "R9 refill 40");
        rd(2'd0, 6'd40, "R9 readback 40");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule